// File: doc/BRIEF.md
# Bit-Serial Fuzzy MAX/MIN Unit

This block compares two fuzzy membership grades that arrive one bit per clock, most significant bit first. In the same cycle as each input pair it emits one bit of the selected result: the larger grade in MAX mode or the smaller grade in MIN mode. No operand word is ever stored. A three-state comparison machine starts each operation in the "equal" state. It moves to "A greater" or "A smaller" on the first bit position where the operands differ, and it keeps that decision until the next reset.

A synchronous reset cycle opens each operation. After it, the caller presents `GRADE_W` qualified bit pairs, and gaps with the strobe low are allowed between them. A done flag rises once the last bit has been consumed. At that point the 2-bit comparison code is the final ordering of the two words. One complete operation therefore needs at least `GRADE_W + 1` cycles.

Top module: `fzs_serial_maxmin`

## Requirements
- R1: A cycle with `rst_i` high leaves the comparison code at 00 (equal) and `done_o` low on the following cycle, whatever state the unit was in before.
- R2: While the code is 00 and the two input bits match, the code stays 00 and `res_bit_o` equals `b_bit_i`. Two equal words therefore produce a result word equal to B and a final code 00.
- R3: On the first qualified bit where a=1 and b=0, the code becomes 01 (A>B). On the first qualified bit where a=0 and b=1, the code becomes 10 (A<B). The code then holds until the next reset.
- R4: With `sel_min_i` low (MAX mode), the output follows `a_bit_i` once A>B has been decided and `b_bit_i` otherwise. The serial output word therefore equals max(A,B).
- R5: With `sel_min_i` high (MIN mode), the output follows `a_bit_i` once A<B has been decided and `b_bit_i` otherwise. The serial output word therefore equals min(A,B).
- R6: On the bit where the operands first differ, `res_bit_o` in that same cycle already reflects the new decision. In MAX mode it is 1 and in MIN mode it is 0.
- R7: A cycle with `bit_vld_i` low changes neither the comparison code nor the bit count, whatever the input bits are.
- R8: `done_o` rises after exactly `GRADE_W` qualified bits following a reset and stays high until the next reset.
- R9: Qualified bits presented while `done_o` is high change neither the comparison code nor `done_o`.
- R10: With no gaps, `done_o` is low during the cycle of the last bit and is high in the cycle after it. A full operation thus spans `GRADE_W + 1` cycles including the reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset; starts a new comparison |
| a_bit_i | input | 1 | Current bit of operand A, MSB first |
| b_bit_i | input | 1 | Current bit of operand B, MSB first |
| sel_min_i | input | 1 | 0 selects MAX, 1 selects MIN |
| bit_vld_i | input | 1 | Qualifies the current bit pair |
| res_bit_o | output | 1 | Current result bit (combinational) |
| cmp_state_o | output | 2 | Comparison code: 00 equal, 01 A>B, 10 A<B |
| done_o | output | 1 | All GRADE_W bits consumed |

## Verification
The result bit is combinational and is due in the same cycle as its input pair. The bench therefore drives each pair on the falling edge and compares `res_bit_o` a quarter period later, before the rising edge that consumes the pair. The comparison code and the done flag are registered and are due one rising edge after the bit that changes them. They are checked on the falling edge that follows that rising edge, in particular in the cycle of the last bit and in the cycle after it. A scoreboard queue holds the expected bit for each qualified pair in the order it was driven. The words rebuilt from the output are also compared with max/min of the operands.

// File: rtl/fzs_pkg.sv
package fzs_pkg;

    // Comparison decision code; values are visible on cmp_state_o.
    typedef enum logic [1:0] {
        CMP_EQ  = 2'b00,
        CMP_AGT = 2'b01,
        CMP_ALT = 2'b10
    } cmp_e;

    typedef struct packed {
        cmp_e state;
    } fsm_st_t;

endpackage

// File: rtl/fzs_bit_judge.sv
// Resolves the decision that applies to the current bit pair.
module fzs_bit_judge
    import fzs_pkg::*;
(
    input  logic a_bit_i,
    input  logic b_bit_i,
    input  cmp_e state_q_i,
    output cmp_e dec_o
);

    always_comb begin
        dec_o = state_q_i;
        if (state_q_i == CMP_EQ) begin
            if (a_bit_i && !b_bit_i) begin
                dec_o = CMP_AGT;
            end else if (!a_bit_i && b_bit_i) begin
                dec_o = CMP_ALT;
            end
        end
    end

endmodule

// File: rtl/fzs_res_mux.sv
// Picks the operand bit that belongs to the selected extreme.
module fzs_res_mux
    import fzs_pkg::*;
#(
    parameter bit MIN_HIGH = 1'b1
) (
    input  logic a_bit_i,
    input  logic b_bit_i,
    input  logic sel_min_i,
    input  cmp_e dec_i,
    output logic res_bit_o
);

    logic pick_a;
    logic min_mode;

    generate
        if (MIN_HIGH) begin : g_min_hi
            assign min_mode = sel_min_i;
        end else begin : g_min_lo
            assign min_mode = !sel_min_i;
        end
    endgenerate

    always_comb begin
        pick_a    = min_mode ? (dec_i == CMP_ALT) : (dec_i == CMP_AGT);
        res_bit_o = pick_a ? a_bit_i : b_bit_i;
    end

endmodule

// File: rtl/fzs_cmp_fsm.sv
// Three-state ordering register; locks on the first differing bit.
module fzs_cmp_fsm
    import fzs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic vld_i,
    input  logic done_i,
    input  cmp_e dec_i,
    output cmp_e state_o
);

    fsm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.state = CMP_EQ;
        end else if (vld_i && !done_i) begin
            st_d.state = dec_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign state_o = st_q.state;

    logic rst_seen_q;
    always_ff @(posedge clk_i) begin
        rst_seen_q <= rst_i;
    end

    p_rst_eq_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_seen_q |-> (st_q.state == CMP_EQ));

    p_lock_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.state != CMP_EQ) |=> $stable(st_q.state));

    p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_i |=> $stable(st_q.state));

    p_after_done_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        done_i |=> $stable(st_q.state));

endmodule

// File: rtl/fzs_bit_ctr.sv
// Counts qualified bits and flags the end of the word.
module fzs_bit_ctr #(
    parameter int GRADE_W = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic vld_i,
    output logic done_o
);

    localparam int CNT_W = $clog2(GRADE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GRADE_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctr_st_t;

    ctr_st_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (rst_i) begin
            ctr_d.cnt  = '0;
            ctr_d.done = 1'b0;
        end else if (vld_i && !ctr_q.done) begin
            ctr_d.cnt  = ctr_q.cnt + 1'b1;
            ctr_d.done = (ctr_d.cnt == LAST);
        end
    end

    always_ff @(posedge clk_i) begin
        ctr_q <= ctr_d;
    end

    assign done_o = ctr_q.done;

    p_cnt_cap_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        ctr_q.cnt <= LAST);

    p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        ctr_q.done |=> ctr_q.done);

    p_done_cause_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ctr_q.done && !vld_i) |=> !ctr_q.done);

endmodule

// File: rtl/fzs_serial_maxmin.sv
module fzs_serial_maxmin
    import fzs_pkg::*;
#(
    parameter int GRADE_W = 8
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       a_bit_i,
    input  logic       b_bit_i,
    input  logic       sel_min_i,
    input  logic       bit_vld_i,
    output logic       res_bit_o,
    output logic [1:0] cmp_state_o,
    output logic       done_o
);

    cmp_e state_q;
    cmp_e dec;
    logic done;

    fzs_bit_judge judge_i (
        .a_bit_i    (a_bit_i),
        .b_bit_i    (b_bit_i),
        .state_q_i  (state_q),
        .dec_o      (dec)
    );

    fzs_res_mux #(.MIN_HIGH(1'b1)) mux_i (
        .a_bit_i    (a_bit_i),
        .b_bit_i    (b_bit_i),
        .sel_min_i  (sel_min_i),
        .dec_i      (dec),
        .res_bit_o  (res_bit_o)
    );

    fzs_cmp_fsm fsm_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .vld_i      (bit_vld_i),
        .done_i     (done),
        .dec_i      (dec),
        .state_o    (state_q)
    );

    fzs_bit_ctr #(.GRADE_W(GRADE_W)) ctr_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .vld_i      (bit_vld_i),
        .done_o     (done)
    );

    assign cmp_state_o = state_q;
    assign done_o      = done;

    p_eq_match_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_vld_i && state_q == CMP_EQ && a_bit_i == b_bit_i) |-> (res_bit_o == b_bit_i));

    p_go_agt_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_vld_i && !done && state_q == CMP_EQ && a_bit_i && !b_bit_i) |=> (state_q == CMP_AGT));

    p_go_alt_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (bit_vld_i && !done && state_q == CMP_EQ && !a_bit_i && b_bit_i) |=> (state_q == CMP_ALT));

    p_max_follow_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sel_min_i && state_q == CMP_AGT) |-> (res_bit_o == a_bit_i));

    p_min_follow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_min_i && state_q == CMP_AGT) |-> (res_bit_o == b_bit_i));

    p_split_bit_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == CMP_EQ && a_bit_i != b_bit_i) |-> (res_bit_o == !sel_min_i));

endmodule

// File: tb/fzs_serial_maxmin_tb_top.sv
module fzs_serial_maxmin_tb_top;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       a_bit_i = 1'b0;
    logic       b_bit_i = 1'b0;
    logic       sel_min_i = 1'b0;
    logic       bit_vld_i = 1'b0;
    logic       res_bit_o;
    logic [1:0] cmp_state_o;
    logic       done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic  exp_q[$];
    string tag_q[$];
    logic [N-1:0] got_word;

    always #10 clk = ~clk;

    fzs_serial_maxmin #(.GRADE_W(N)) dut_i (
        .clk_i       (clk),
        .rst_i       (rst_i),
        .a_bit_i     (a_bit_i),
        .b_bit_i     (b_bit_i),
        .sel_min_i   (sel_min_i),
        .bit_vld_i   (bit_vld_i),
        .res_bit_o   (res_bit_o),
        .cmp_state_o (cmp_state_o),
        .done_o      (done_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Monitor: compares each qualified output bit against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (bit_vld_i && exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                got_word = {got_word[N-2:0], res_bit_o};
                check(t, {31'd0, res_bit_o}, {31'd0, e});
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_i = 1'b1;
        bit_vld_i = 1'b0;
        @(negedge clk);
        rst_i = 1'b0;
        #5;
        check("R1 code", {30'd0, cmp_state_o}, 32'd0);
        check("R1 done", {31'd0, done_o}, 32'd0);
    endtask

    task automatic run_op(input logic [N-1:0] aw, input logic [N-1:0] bw,
                          input logic mode, input bit gaps);
        logic [N-1:0] want;
        logic [1:0]   want_code;
        bit           split_seen;
        string        base;
        want      = mode ? ((aw < bw) ? aw : bw) : ((aw > bw) ? aw : bw);
        want_code = (aw > bw) ? 2'b01 : ((aw < bw) ? 2'b10 : 2'b00);
        base      = (aw == bw) ? "R2" : (mode ? "R5" : "R4");
        split_seen = 1'b0;
        got_word   = '0;
        do_reset();
        for (int i = N - 1; i >= 0; i--) begin
            if (gaps && ($urandom % 2 == 0)) begin
                @(negedge clk);
                bit_vld_i = 1'b0;
                a_bit_i   = 1'($urandom);
                b_bit_i   = !a_bit_i;
            end
            @(negedge clk);
            a_bit_i   = aw[i];
            b_bit_i   = bw[i];
            sel_min_i = mode;
            bit_vld_i = 1'b1;
            exp_q.push_back(want[i]);
            if (!split_seen && aw[i] != bw[i]) begin
                split_seen = 1'b1;
                tag_q.push_back("R6 split bit");
            end else begin
                tag_q.push_back(base);
            end
            if (i == 0) begin
                #6;
                check("R10 done low on last bit", {31'd0, done_o}, 32'd0);
            end
        end
        @(negedge clk);
        bit_vld_i = 1'b0;
        #6;
        check("R10 done next cycle", {31'd0, done_o}, 32'd1);
        check(gaps ? "R7 code after gaps" : "R3 final code", {30'd0, cmp_state_o}, {30'd0, want_code});
        check({base, " word"}, {{(32-N){1'b0}}, got_word}, {{(32-N){1'b0}}, want});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_i = 1'b0;

        // R7: idle cycles with differing bits leave code and count alone.
        do_reset();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            a_bit_i = 1'b1;
            b_bit_i = 1'b0;
            bit_vld_i = 1'b0;
        end
        #6;
        check("R7 idle code", {30'd0, cmp_state_o}, 32'd0);
        check("R7 idle done", {31'd0, done_o}, 32'd0);

        // Directed operands.
        run_op(8'h5A, 8'h5A, 1'b0, 1'b0);
        run_op(8'h3C, 8'h3C, 1'b1, 1'b0);
        run_op(8'h80, 8'h7F, 1'b0, 1'b0);
        run_op(8'h80, 8'h7F, 1'b1, 1'b0);
        run_op(8'h5A, 8'h5B, 1'b0, 1'b0);
        run_op(8'h5A, 8'h5B, 1'b1, 1'b0);
        run_op(8'h00, 8'hFF, 1'b0, 1'b1);
        run_op(8'hFF, 8'h00, 1'b1, 1'b1);

        // R9: extra qualified bits after done are ignored.
        run_op(8'hC3, 8'hA5, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            a_bit_i = 1'b0;
            b_bit_i = 1'b1;
            bit_vld_i = 1'b1;
        end
        @(negedge clk);
        bit_vld_i = 1'b0;
        #6;
        check("R9 code after done", {30'd0, cmp_state_o}, 32'd1);
        check("R9 done held", {31'd0, done_o}, 32'd1);

        // R1: reset clears a locked decision.
        do_reset();

        // Random operands, both modes, with and without gaps.
        for (int k = 0; k < 40; k++) begin
            run_op(N'($urandom), N'($urandom), 1'($urandom), k[0]);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule